// File: doc/BRIEF.md
# Double-Buffered Output Handshake Port

This block sits between a bus-side write interface and an external peripheral. Bytes written by the bus master go into a two-entry queue. The head entry, the final stage, drives the port pins. The entry behind it, the initial stage, waits its turn. When the peripheral takes the byte on the pins, the waiting byte moves forward on the next clock. The peripheral signals that it has taken a byte with a rising edge on an acknowledge input. That input passes through a two-flop synchronizer before the block reacts to it.

Towards the peripheral the block drives a data-ready strobe in one of two styles. In the level style, the strobe stays high while data waits and drops for one cycle when an acknowledge is taken. In the pulsed style, each newly loaded byte gets a strobe of at most four cycles, and an acknowledge cuts the strobe short. A status bit reports the buffer to software, either as "room for another byte" or as "completely drained". A DMA request can be tied to this output path. In the 16-bit paired mode, a write to the high-byte register is parked in a holding latch. A later write to the low-byte register pushes both bytes as one 16-bit entry, and that second write is the only one the status and handshake logic sees.

Top module: `dbo_out_port`

## Requirements
- R1: In byte mode every write (either `wr_sel_i` value) enqueues `{8'h00, wr_data_i}`. Entries reach `port_o` in write order. A write into an empty buffer appears on `port_o` at the clock after the write.
- R2: A rising edge on `ack_i` takes effect 3 clock edges after the first edge at which `ack_i` is high (two synchronizer flops, then the edge flop). At that edge the byte on `port_o` is consumed, and the waiting byte, if any, loads into the final stage.
- R3: With `stat_sel_i`=0, `room_stat_o` is 1 when fewer than two entries are held. With `stat_sel_i`=1, it is 1 only when both stages are empty.
- R4: With `pulse_mode_i`=0, `strobe_o` = `hs_en_i` AND (final stage full) AND NOT (a synchronized acknowledge edge is present this cycle). The value on `port_o` is constant while `strobe_o` stays high.
- R5: An acknowledge edge that arrives while the final stage is empty, or while `hs_en_i`=0, consumes nothing.
- R6: With `pulse_mode_i`=1, the strobe for each newly loaded entry is high for at most 4 enabled cycles. A synchronized acknowledge edge ends it early.
- R7: `strobe_stat_o` is always 0, and `strobe_o` is 0 whenever `hs_en_i`=0.
- R8: With `pair_mode_i`=1, a write with `wr_sel_i`=0 only loads the holding latch. A write with `wr_sel_i`=1 enqueues `{hold, wr_data_i}`.
- R9: `dma_req_o` = `dma_en_i` AND `dma_out_side_i` AND (fewer than two entries held). It is 0 when `dma_out_side_i`=0.
- R10: A write made while both stages stay full through that cycle is dropped, and `ovf_o` sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_sel_i | input | 1 | Register select: 0 high-byte, 1 low-byte |
| wr_data_i | input | DATA_W | Write data |
| pair_mode_i | input | 1 | 16-bit paired mode |
| pulse_mode_i | input | 1 | 0 level strobe, 1 pulsed strobe |
| hs_en_i | input | 1 | Handshake enable |
| stat_sel_i | input | 1 | 0 room status, 1 drained status |
| dma_en_i | input | 1 | DMA request enable |
| dma_out_side_i | input | 1 | DMA request tied to output path |
| ack_i | input | 1 | Peripheral acknowledge (asynchronous) |
| port_o | output | 2*DATA_W | Final-stage data on the port pins |
| strobe_o | output | 1 | Data-ready strobe to peripheral |
| room_stat_o | output | 1 | Selectable buffer status bit |
| strobe_stat_o | output | 1 | Strobe status bit, always 0 |
| dma_req_o | output | 1 | DMA request |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check several rules on every cycle. The strobe is gated by the enable, and the DMA request stays low when it is tied away from this path. The port data holds steady under a continuous strobe, and a pulsed strobe never runs longer than its limit. Overflow is sticky, and the drained status never coincides with a strobe. Other behaviour only shows in the bench's scenarios against its queue model. Those scenarios cover FIFO ordering, the three-edge acknowledge latency, ignored acknowledges, early pulse cut-off, the paired 16-bit commit and the choice of which write gets dropped.

// File: rtl/dbo_pkg.sv
package dbo_pkg;
  typedef enum logic {HS_LEVEL = 1'b0, HS_PULSE = 1'b1} hs_mode_e;
  typedef enum logic {ST_ROOM = 1'b0, ST_DRAINED = 1'b1} stat_mode_e;
endpackage

// File: rtl/dbo_ack_sync.sv
module dbo_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ack_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dbo_buffer.sv
module dbo_buffer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                pair_i,
  input  logic                pop_i,
  output logic [2*DATA_W-1:0] fin_data_o,
  output logic                fin_v_o,
  output logic                ini_v_o,
  output logic                load_o,
  output logic                ovf_o
);
  localparam int unsigned EW = 2 * DATA_W;

  logic [DATA_W-1:0] hold_q;
  logic [EW-1:0]     fin_q, ini_q, entry;
  logic              fin_v_q, ini_v_q, ovf_q;
  logic              push, stay_fin, drop, take;

  assign push     = wr_en_i & (~pair_i | wr_sel_i);
  assign entry    = pair_i ? {hold_q, wr_data_i} : {{DATA_W{1'b0}}, wr_data_i};
  assign stay_fin = fin_v_q & ~pop_i;
  assign drop     = push & stay_fin & ini_v_q;
  assign take     = push & ~drop;
  assign load_o   = ~stay_fin & (ini_v_q | take);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      fin_q   <= '0;
      ini_q   <= '0;
      fin_v_q <= 1'b0;
      ini_v_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_en_i & pair_i & ~wr_sel_i) hold_q <= wr_data_i;
      if (drop) ovf_q <= 1'b1;
      if (stay_fin) begin
        if (!ini_v_q && take) begin
          ini_q   <= entry;
          ini_v_q <= 1'b1;
        end
      end else if (ini_v_q) begin
        // advance waiting entry, refill behind it
        fin_q   <= ini_q;
        fin_v_q <= 1'b1;
        ini_v_q <= take;
        if (take) ini_q <= entry;
      end else begin
        fin_v_q <= take;
        if (take) fin_q <= entry;
      end
    end
  end

  assign fin_data_o = fin_q;
  assign fin_v_o    = fin_v_q;
  assign ini_v_o    = ini_v_q;
  assign ovf_o      = ovf_q;
endmodule

// File: rtl/dbo_strobe.sv
module dbo_strobe #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_en_i,
  input  logic pulse_i,
  input  logic fin_v_i,
  input  logic load_i,
  input  logic edge_i,
  output logic strobe_o
);
  import dbo_pkg::*;
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          in_window;
  hs_mode_e      mode;

  assign mode      = hs_mode_e'(pulse_i);
  assign in_window = cnt_q < CW'(PULSE_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (load_i)                           cnt_q <= '0;
    else if (hs_en_i && fin_v_i && in_window)  cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = hs_en_i & fin_v_i & ~edge_i & ((mode == HS_LEVEL) | in_window);
endmodule

// File: rtl/dbo_out_port.sv
module dbo_out_port #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                pair_mode_i,
  input  logic                pulse_mode_i,
  input  logic                hs_en_i,
  input  logic                stat_sel_i,
  input  logic                dma_en_i,
  input  logic                dma_out_side_i,
  input  logic                ack_i,
  output logic [2*DATA_W-1:0] port_o,
  output logic                strobe_o,
  output logic                room_stat_o,
  output logic                strobe_stat_o,
  output logic                dma_req_o,
  output logic                ovf_o
);
  import dbo_pkg::*;

  logic       ack_edge, pop, fin_v, ini_v, load;
  stat_mode_e smode;

  dbo_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .edge_o(ack_edge)
  );

  assign pop = ack_edge & hs_en_i & fin_v;

  dbo_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .pair_i(pair_mode_i), .pop_i(pop),
    .fin_data_o(port_o), .fin_v_o(fin_v), .ini_v_o(ini_v),
    .load_o(load), .ovf_o(ovf_o)
  );

  dbo_strobe #(.PULSE_CYCLES(PULSE_CYCLES)) u_stb (
    .clk_i(clk_i), .rst_ni(rst_ni), .hs_en_i(hs_en_i), .pulse_i(pulse_mode_i),
    .fin_v_i(fin_v), .load_i(load), .edge_i(ack_edge), .strobe_o(strobe_o)
  );

  assign smode         = stat_mode_e'(stat_sel_i);
  assign room_stat_o   = (smode == ST_DRAINED) ? ~(fin_v | ini_v) : ~(fin_v & ini_v);
  assign strobe_stat_o = 1'b0;
  assign dma_req_o     = dma_en_i & dma_out_side_i & ~(fin_v & ini_v);
endmodule

// File: rtl/dbo_checker.sv
module dbo_checker #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PULSE_CYCLES = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hs_en_i,
  input logic                pulse_mode_i,
  input logic                stat_sel_i,
  input logic                dma_out_side_i,
  input logic [2*DATA_W-1:0] port_o,
  input logic                strobe_o,
  input logic                room_stat_o,
  input logic                dma_req_o,
  input logic                ovf_o
);
  localparam int unsigned RW = $clog2(PULSE_CYCLES + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (strobe_o && pulse_mode_i)  run_q <= (run_q > RW'(PULSE_CYCLES)) ? run_q : run_q + 1'b1;
    else                                run_q <= '0;
  end

  AST_STROBE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_en_i |-> !strobe_o); // R7
  AST_DMA_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_out_side_i |-> !dma_req_o); // R9
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RW'(PULSE_CYCLES)); // R6
  AST_PORT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && $past(strobe_o)) |-> $stable(port_o)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ovf_o) |-> ovf_o); // R10
  AST_DRAINED_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_sel_i && room_stat_o) |-> !strobe_o); // R3
endmodule

bind dbo_out_port dbo_checker #(.DATA_W(DATA_W), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_en_i(hs_en_i), .pulse_mode_i(pulse_mode_i),
  .stat_sel_i(stat_sel_i), .dma_out_side_i(dma_out_side_i), .port_o(port_o),
  .strobe_o(strobe_o), .room_stat_o(room_stat_o), .dma_req_o(dma_req_o), .ovf_o(ovf_o)
);

// File: tb/tb_dbo_out_port.sv
module tb_dbo_out_port;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 4;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, wr_sel = 0, pair = 0, pulse = 0, hs_en = 0;
  logic        stat_sel = 0, dma_en = 0, dma_side = 0, ack = 0;
  logic [7:0]  wr_data = '0;
  logic [15:0] port;
  logic        strobe, room, h2s, dma_req, ovf;

  int checks = 0, fails = 0, cycles = 0;
  string phase = "reset";
  bit done = 0;

  dbo_out_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .pair_mode_i(pair), .pulse_mode_i(pulse), .hs_en_i(hs_en), .stat_sel_i(stat_sel),
    .dma_en_i(dma_en), .dma_out_side_i(dma_side), .ack_i(ack),
    .port_o(port), .strobe_o(strobe), .room_stat_o(room), .strobe_stat_o(h2s),
    .dma_req_o(dma_req), .ovf_o(ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [15:0] mq[$];
  logic [15:0] m_port;
  logic [7:0]  m_hold;
  bit          m_s0, m_s1, m_prev, m_ovf;
  int          m_cnt;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s [%s] actual=%0h expected=%0h t=%0t", req, what, phase, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    bit e, pop, inc, loaded;
    int sz0;
    logic [15:0] ent;
    if (!rst_n) begin
      mq.delete(); m_port = '0; m_hold = '0;
      m_s0 = 0; m_s1 = 0; m_prev = 0; m_ovf = 0; m_cnt = 0;
    end else begin
      e   = m_s1 & ~m_prev;
      sz0 = mq.size();
      pop = e && hs_en && sz0 > 0;
      inc = hs_en && sz0 > 0 && m_cnt < PULSE;
      if (pop) void'(mq.pop_front());
      if (wr_en && (!pair || wr_sel)) begin
        ent = pair ? {m_hold, wr_data} : {8'h00, wr_data};
        if (mq.size() < 2) mq.push_back(ent);
        else m_ovf = 1;
      end
      if (wr_en && pair && !wr_sel) m_hold = wr_data;
      loaded = (pop || sz0 == 0) && mq.size() > 0;
      if (loaded) begin m_port = mq[0]; m_cnt = 0; end
      else if (inc) m_cnt++;
      m_prev = m_s1; m_s1 = m_s0; m_s0 = ack;
    end
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      bit e2, fv;
      e2 = m_s1 & ~m_prev;
      fv = mq.size() > 0;
      chk("R1", port, m_port, "port_o");
      chk("R4", strobe, hs_en & fv & ~e2 & (!pulse | (m_cnt < PULSE)), "strobe_o");
      chk("R3", room, stat_sel ? (mq.size() == 0) : (mq.size() < 2), "room_stat_o");
      chk("R7", h2s, 0, "strobe_stat_o");
      chk("R9", dma_req, dma_en & dma_side & (mq.size() < 2), "dma_req_o");
      chk("R10", ovf, m_ovf, "ovf_o");
    end
  end

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected<=%0d", cycles, WD_LIMIT);
      summary();
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic ack_pulse(int hi);
    @(negedge clk); ack = 1; idle(hi); ack = 0; idle(3);
  endtask

  initial begin
    idle(2);
    phase = "reset";
    chk("R1", port, 16'h0, "reset port_o");
    chk("R4", strobe, 0, "reset strobe_o");
    chk("R3", room, 1, "reset room_stat_o");
    chk("R10", ovf, 0, "reset ovf_o");
    @(negedge clk); rst_n = 1;
    hs_en = 1;

    phase = "R1 R2 level fifo";
    wr(0, 8'h11); wr(1, 8'h22); idle(2);
    ack_pulse(3); idle(2);
    ack_pulse(5); idle(3);

    phase = "R5 ack on empty";
    ack_pulse(2); idle(2);
    phase = "R5 ack while disabled";
    wr(1, 8'h33); hs_en = 0; ack_pulse(2); idle(2);
    phase = "R7 re-enable"; hs_en = 1; idle(2);
    ack_pulse(2);

    phase = "R3 drained status";
    stat_sel = 1; wr(1, 8'h44); wr(1, 8'h55); idle(2);
    ack_pulse(2); ack_pulse(2); idle(3); stat_sel = 0;

    phase = "R6 pulsed full";
    pulse = 1; wr(1, 8'h66); idle(8);
    ack_pulse(2);
    phase = "R6 pulsed cut short";
    wr(1, 8'h77); wr(1, 8'h78);
    @(negedge clk); ack = 1; idle(1); ack = 0; idle(6);
    ack_pulse(2); pulse = 0; idle(2);

    phase = "R8 paired";
    pair = 1; wr(0, 8'hAB); idle(2); wr(1, 8'hCD); idle(2);
    wr(0, 8'h12); wr(0, 8'h34); wr(1, 8'h56); idle(2);
    ack_pulse(2); ack_pulse(2); pair = 0;

    phase = "R9 dma";
    dma_en = 1; dma_side = 1; idle(2);
    wr(1, 8'h81); wr(1, 8'h82); idle(2);
    dma_side = 0; idle(2); dma_side = 1;

    phase = "R10 overflow";
    wr(1, 8'h83); idle(3);
    ack_pulse(2); ack_pulse(2); idle(2);
    wr(1, 8'h90); idle(4);
    dma_en = 0; ack_pulse(2);

    summary();
  end
endmodule